// File: doc/BRIEF.md
# Sampling-Converter Serial Port Engine

This block is the digital side of a 16-channel, 12-bit sampling converter's serial port. A host frames each transfer with an active-low select and clocks it with a serial clock that idles high. Each frame of 16 serial-clock falling edges returns a 4-bit channel tag and then the 12-bit result for that channel. On the same edges the host shifts in a control word. Conversion itself is not modelled: each channel's result comes from a parallel input bus. The port also reports whether the front-end sampler is tracking or holding.

A control word can pick a fixed channel or ask for a channel mask. After a mask request, the whole of the next frame's input is taken as a 16-bit enable mask. The engine then visits the enabled channels in turn, moving upward and wrapping around. The output driver has three states: strong drive, weak hold of the last bit, or off.

All pins are sampled on the system clock `clk`. The host must hold each pin level for at least one `clk` cycle. The serial pins form a fixed-timing protocol with no flow control, so no valid/ready handshake applies. The host paces the frame with the serial clock, and the channel results are sampled rather than streamed, so neither side can apply back-pressure.

Top module: `adc_serial_port`

## Requirements
- R1: After reset, `dout_en`=0, `dout_weak`=0, `dout`=0 and `track`=1. The channel is 0, the weak-hold bit is 0 and the channel sequencer is off.
- R2: One `clk` after `cs_n` falls, `track` is 0 (hold) and `dout_en` is 1.
- R3: The output word is the 4-bit channel tag followed by the 12-bit result, each sent MSB first. The tag MSB is on `dout` before the first serial-clock fall. Each later bit appears after the next fall. The last bit appears after the 15th fall and is not shifted away by the 16th.
- R4: On the 16th fall, strong drive stops. If the weak bit is 0, `dout_en`=0 and `dout_weak`=0.
- R5: In a normal frame, `track` returns to 1 on the 14th fall. It is still 0 after the 13th fall.
- R6: The control word is the first 12 input bits of a frame; the first bit received is control bit 11. Control bit 11 is the write enable, and with it at 0 the word has no effect. Control bit 10 requests a mask load. Control bit 9 is the weak-hold bit. Control bits 8:5 hold the channel, MSB first. A write takes effect when `cs_n` rises after a complete frame. A channel write selects the tagged channel for the following frame and turns the sequencer off.
- R7: With the weak bit at 1, after the 16th fall `dout_weak`=1 and `dout` holds the last data bit.
- R8: After a write with bit 10 set, the next complete frame loads all 16 input bits as the enable mask. The first bit received enables channel 0. During that frame `track` stays 0 until `cs_n` rises.
- R9: After a mask load, the next frame converts the lowest enabled channel. An all-zero mask selects channel 0.
- R10: With the sequencer on, each complete frame that carries no write moves to the next enabled channel above the current one, wrapping from 15 to 0. A single enabled channel repeats.
- R11: If `cs_n` rises before the 16th fall, nothing is written and the channel does not advance. A pending mask load stays pending. `track` returns to 1 and the driver goes to its idle state.
- R12: Serial-clock falls while `cs_n` is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all pins sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock, idles high, active on falling edges |
| din | input | 1 | Serial control or mask input |
| ch_data | input | 192 | Per-channel 12-bit results, channel c at bits [12c+11:12c] |
| dout | output | 1 | Serial data output value |
| dout_en | output | 1 | Strong drive enable for `dout` |
| dout_weak | output | 1 | Weak hold drive of `dout` |
| track | output | 1 | 1 = sampler tracking, 0 = holding |

## Verification
Each pin event is seen on the first `clk` rising edge after it. Every output it causes is registered there, so the output is due exactly one `clk` later. The bench changes pins on falling `clk` edges and reads outputs at the next falling edge or later. It therefore never samples in the cycle of the change. Frame bits are read just before the next serial-clock fall. `track` and the driver state are read after the 13th, 14th and 16th falls and again after `cs_n` rises.

// File: rtl/asp_pkg.sv
package asp_pkg;
  typedef enum logic [1:0] {
    DRV_OFF    = 2'd0,
    DRV_STRONG = 2'd1,
    DRV_WEAK   = 2'd2
  } drv_e;
endpackage

// File: rtl/asp_edges.sv
module asp_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  output logic cs_fall,
  output logic cs_rise,
  output logic sclk_fall
);
  logic cs_q, sclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b1;
    end else begin
      cs_q   <= cs_n;
      sclk_q <= sclk;
    end
  end

  assign cs_fall   = cs_q & ~cs_n;
  assign cs_rise   = ~cs_q & cs_n;
  // only count serial clock edges inside an already open frame
  assign sclk_fall = sclk_q & ~sclk & ~cs_n & ~cs_q;
endmodule

// File: rtl/asp_seq.sv
module asp_seq #(
  parameter int NCH = 16,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ld_chan,
  input  logic [CHW-1:0] new_chan,
  input  logic           ld_mask,
  input  logic [NCH-1:0] new_mask,
  input  logic           advance,
  output logic [CHW-1:0] chan
);
  logic [NCH-1:0] mask_q;
  logic           seq_on;
  logic [CHW-1:0] next_up, first_set;

  // next enabled channel above the current one, wrapping
  always_comb begin
    logic found;
    logic [CHW-1:0] idx;
    found   = 1'b0;
    next_up = chan;
    for (int k = 1; k <= NCH; k++) begin
      idx = CHW'((int'(chan) + k) % NCH);
      if (!found && mask_q[idx]) begin
        next_up = idx;
        found   = 1'b1;
      end
    end
  end

  // lowest enabled channel of a freshly loaded mask
  always_comb begin
    logic found;
    found     = 1'b0;
    first_set = '0;
    for (int k = 0; k < NCH; k++) begin
      if (!found && new_mask[k]) begin
        first_set = CHW'(k);
        found     = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chan   <= '0;
      mask_q <= '0;
      seq_on <= 1'b0;
    end else if (ld_mask) begin
      mask_q <= new_mask;
      seq_on <= 1'b1;
      chan   <= first_set;
    end else if (ld_chan) begin
      seq_on <= 1'b0;
      chan   <= new_chan;
    end else if (advance && seq_on) begin
      chan <= next_up;
    end
  end

  AST_MASK_PICK: assert property (@(posedge clk) disable iff (!rst_n)
    ld_mask |=> (mask_q[chan] || mask_q == '0)); // R9
  AST_SEQ_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && seq_on && !ld_mask && !ld_chan && mask_q != '0) |=> mask_q[chan]); // R10
  AST_CHAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_mask || ld_chan || advance) |=> $stable(chan)); // R11
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port #(
  parameter int NCH    = 16,
  parameter int DW     = 12,
  parameter int CTRL_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              din,
  input  logic [NCH*DW-1:0] ch_data,
  output logic              dout,
  output logic              dout_en,
  output logic              dout_weak,
  output logic              track
);
  import asp_pkg::*;

  localparam int CHW   = $clog2(NCH);
  localparam int FRAME = CHW + DW;
  localparam int CNTW  = $clog2(FRAME + 1);
  localparam int CB_WR   = CTRL_W - 1;
  localparam int CB_MASK = CTRL_W - 2;
  localparam int CB_WEAK = CTRL_W - 3;
  localparam int CB_CHLO = CTRL_W - 3 - CHW;
  localparam logic [CNTW-1:0] C_FRAME = CNTW'(FRAME);
  localparam logic [CNTW-1:0] C_LAST  = CNTW'(FRAME - 1);
  localparam logic [CNTW-1:0] C_CTRL  = CNTW'(CTRL_W);
  localparam logic [CNTW-1:0] C_TRK   = CNTW'(FRAME - 3);

  logic cs_fall, cs_rise, sclk_fall;
  logic [CNTW-1:0]  cnt;
  logic [FRAME-1:0] shreg;
  logic [CTRL_W-1:0] ctrl_sr;
  logic [NCH-1:0]   mask_sr;
  logic             active, in_mask, mask_pend, weak_q, track_q;
  drv_e             drv;
  logic [CHW-1:0]   chan;
  logic [DW-1:0]    res;
  logic             end_ok, ld_mask, ctrl_wr, ld_chan, advance;
  drv_e             idle_drv;

  asp_edges u_edges (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
    .cs_fall(cs_fall), .cs_rise(cs_rise), .sclk_fall(sclk_fall)
  );

  assign res      = ch_data[chan*DW +: DW];
  assign end_ok   = cs_rise & active & (cnt == C_FRAME);
  assign ld_mask  = end_ok & in_mask;
  assign ctrl_wr  = end_ok & ~in_mask & ctrl_sr[CB_WR];
  assign ld_chan  = ctrl_wr & ~ctrl_sr[CB_MASK];
  assign advance  = end_ok & ~in_mask & ~ctrl_sr[CB_WR];
  assign idle_drv = weak_q ? DRV_WEAK : DRV_OFF;

  asp_seq #(.NCH(NCH)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .ld_chan(ld_chan), .new_chan(ctrl_sr[CB_CHLO +: CHW]),
    .ld_mask(ld_mask), .new_mask(mask_sr),
    .advance(advance), .chan(chan)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      shreg     <= '0;
      ctrl_sr   <= '0;
      mask_sr   <= '0;
      active    <= 1'b0;
      in_mask   <= 1'b0;
      mask_pend <= 1'b0;
      weak_q    <= 1'b0;
      track_q   <= 1'b1;
      drv       <= DRV_OFF;
    end else if (cs_fall) begin
      // sample, hold and start driving the channel tag
      cnt     <= '0;
      shreg   <= {chan, res};
      ctrl_sr <= '0;
      active  <= 1'b1;
      in_mask <= mask_pend;
      track_q <= 1'b0;
      drv     <= DRV_STRONG;
    end else if (sclk_fall && active && cnt < C_FRAME) begin
      cnt     <= cnt + 1'b1;
      if (cnt < C_LAST) shreg <= {shreg[FRAME-2:0], 1'b0};
      if (cnt < C_CTRL) ctrl_sr <= {ctrl_sr[CTRL_W-2:0], din};
      mask_sr <= {din, mask_sr[NCH-1:1]};
      if (cnt == C_TRK && !in_mask) track_q <= 1'b1;
      if (cnt == C_LAST) drv <= idle_drv;
    end else if (cs_rise && active) begin
      active  <= 1'b0;
      in_mask <= 1'b0;
      track_q <= 1'b1;
      if (!end_ok) drv <= idle_drv;
      if (ld_mask) mask_pend <= 1'b0;
      if (ctrl_wr) begin
        weak_q <= ctrl_sr[CB_WEAK];
        if (ctrl_sr[CB_MASK]) mask_pend <= 1'b1;
      end
    end
  end

  assign dout      = (drv != DRV_OFF) ? shreg[FRAME-1] : 1'b0;
  assign dout_en   = (drv == DRV_STRONG);
  assign dout_weak = (drv == DRV_WEAK);
  assign track     = track_q;

  AST_CSFALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> (!track && dout_en)); // R2
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= C_FRAME); // R3
  AST_MASK_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (active && in_mask) |-> !track); // R8
  AST_ABORT_NOWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && active && cnt != C_FRAME) |=> ($stable(weak_q) && $stable(mask_pend))); // R11
  AST_WRITE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (end_ok && !in_mask && !ctrl_sr[CB_WR]) |=> $stable(weak_q)); // R6
  AST_IDLE_SCLK: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n)) |=> $stable(cnt)); // R12
endmodule

// File: tb/adc_serial_port_tb.sv
module adc_serial_port_tb;
  localparam int PERIOD = 10;
  localparam int NV = 14;
  // {din word[21:6], expected channel[5:2], mask frame[1], weak hold[0]}
  localparam logic [21:0] VEC [NV] = '{
    {16'h0000, 4'd0,  1'b0, 1'b0},
    {16'h8A00, 4'd0,  1'b0, 1'b0},
    {16'h0000, 4'd5,  1'b0, 1'b0},
    {16'h0000, 4'd5,  1'b0, 1'b0},
    {16'h7700, 4'd5,  1'b0, 1'b0},
    {16'h0000, 4'd5,  1'b0, 1'b0},
    {16'hC000, 4'd5,  1'b0, 1'b0},
    {16'h1042, 4'd5,  1'b1, 1'b0},
    {16'h0000, 4'd3,  1'b0, 1'b0},
    {16'h0000, 4'd9,  1'b0, 1'b0},
    {16'h0000, 4'd14, 1'b0, 1'b0},
    {16'h0000, 4'd3,  1'b0, 1'b0},
    {16'hA400, 4'd9,  1'b0, 1'b0},
    {16'h0000, 4'd2,  1'b0, 1'b1}
  };

  logic clk = 0, rst_n = 0, cs_n = 1, sclk = 1, din = 0;
  logic [16*12-1:0] ch_data;
  logic dout, dout_en, dout_weak, track;
  int checks = 0, errors = 0;

  adc_serial_port u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .ch_data(ch_data), .dout(dout), .dout_en(dout_en),
    .dout_weak(dout_weak), .track(track)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [11:0] val(input int c);
    logic [3:0] n;
    n = 4'(c);
    return {n, ~n, n ^ 4'hA};
  endfunction

  function automatic logic [15:0] word(input int c);
    return {4'(c), val(c)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [15:0] w, input int nf, output logic [15:0] got,
                       output logic [15:0] trk, output logic en16, output logic wk16,
                       output logic d16);
    got = '0; trk = '0;
    @(negedge clk) cs_n = 0;
    @(negedge clk);
    chk(!track && dout_en, "R2 hold and drive after select", {track, dout_en}, 2'b01);
    for (int i = 0; i < nf; i++) begin
      got[15-i] = dout;
      din = w[15-i]; sclk = 0;
      @(negedge clk) sclk = 1;
      @(negedge clk) trk[i] = track;
    end
    en16 = dout_en; wk16 = dout_weak; d16 = dout;
    @(negedge clk) begin cs_n = 1; din = 0; end
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] got, trk;
    logic en16, wk16, d16;
    for (int c = 0; c < 16; c++) ch_data[c*12 +: 12] = val(c);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!dout_en && !dout_weak && !dout && track, "R1 reset outputs",
        {dout_en, dout_weak, dout, track}, 4'b0001);

    for (int v = 0; v < NV; v++) begin
      logic [15:0] w;
      int ch;
      logic mf, wk;
      w = VEC[v][21:6]; ch = int'(VEC[v][5:2]); mf = VEC[v][1]; wk = VEC[v][0];
      frame(w, 16, got, trk, en16, wk16, d16);
      // R3 R6 R9 R10: tag and data word of the expected channel
      chk(got == word(ch), "R3 R6 R9 R10 frame word", got, word(ch));
      chk(trk[12] == 1'b0, "R5 still hold after 13th fall", trk[12], 1'b0);
      chk(trk[13] == !mf, "R5 R8 track after 14th fall", trk[13], !mf);
      if (mf) chk(trk[15] == 1'b0, "R8 hold to end of mask frame", trk[15], 1'b0);
      chk(!en16 && wk16 == wk, "R4 R7 driver after 16th fall", {en16, wk16}, {1'b0, wk});
      if (wk) chk(d16 == val(ch)[0], "R7 weak hold keeps last bit", d16, val(ch)[0]);
      chk(track == 1'b1, "R8 track after select rises", track, 1'b1);
    end

    // R12: serial clock toggles with select high
    for (int i = 0; i < 5; i++) begin
      @(negedge clk) begin sclk = 0; din = 1; end
      @(negedge clk) sclk = 1;
    end
    din = 0;
    frame(16'h0000, 16, got, trk, en16, wk16, d16);
    chk(got == word(2), "R12 idle clocks ignored", got, word(2));

    // R11: aborted channel write
    frame(16'h8C00, 8, got, trk, en16, wk16, d16);
    chk(track && dout_weak && !dout_en, "R11 abort idles driver",
        {track, dout_weak, dout_en}, 3'b110);
    frame(16'h0000, 16, got, trk, en16, wk16, d16);
    chk(got == word(2), "R11 aborted write not applied", got, word(2));

    // R11 R8: aborted mask frame stays pending
    frame(16'hC000, 16, got, trk, en16, wk16, d16);
    chk(got == word(2), "R6 mask request frame", got, word(2));
    frame(16'h0001, 10, got, trk, en16, wk16, d16);
    chk(trk[9] == 1'b0, "R8 hold in aborted mask frame", trk[9], 1'b0);
    frame(16'h0001, 16, got, trk, en16, wk16, d16);
    chk(got == word(2), "R11 mask still pending", got, word(2));
    frame(16'h0000, 16, got, trk, en16, wk16, d16);
    chk(got == word(15), "R9 lowest enabled channel", got, word(15));
    frame(16'h0000, 16, got, trk, en16, wk16, d16);
    chk(got == word(15), "R10 single channel repeats", got, word(15));

    // R9: zero mask selects channel 0
    frame(16'hC000, 16, got, trk, en16, wk16, d16);
    frame(16'h0000, 16, got, trk, en16, wk16, d16);
    chk(got == word(15), "R8 zero mask frame", got, word(15));
    frame(16'h0000, 16, got, trk, en16, wk16, d16);
    chk(got == word(0), "R9 zero mask gives channel 0", got, word(0));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule